// File: doc/BRIEF.md
# Circular and Bit-Reversed Pointer Unit

This block is the address arithmetic unit for a bank of eight 16-bit data pointers. Each cycle it takes at most one request. A request names a pointer, an update opcode, a 16-bit constant and the current circular buffer length. The block returns the access address one cycle later and writes the modified pointer back into the bank. Pointer 0 also acts as the index register for the index-stepped and bit-reversed opcodes.

Circular opcodes wrap inside a buffer whose base comes from the pointer itself. If the length N needs nb bits, the base is the pointer with its nb low bits cleared, and the last entry is base + N − 1. The bit-reversed opcodes propagate the carry from the most significant bit toward the least significant bit, which produces FFT reordering sequences. A dual-operand flag applies the restricted pointer and opcode set of a paired access. Any request that breaks that set is refused with an error flag.

Top module: `ptr_unit`

## Requirements
- R1: After reset, addr_o, addr_valid_o and err_o are 0, and every pointer reads as 0000h.
- R2: A request accepted on a clock edge (req_valid_i=1 and not refused) gives addr_valid_o=1 and its address on addr_o after that edge. The pointer write-back is visible to the next request. With req_valid_i=0, addr_valid_o and err_o are 0 after the edge, and no pointer changes.
- R3: Linear opcodes return the old pointer p as the address and wrap modulo 2^16. The codes are 0 (none: p kept), 1 (p+1), 2 (p−1), 3 (p+index) and 4 (p−index). Code 14 loads the constant into the pointer and returns it as the address.
- R4: Opcode 5 returns p+constant and leaves p unchanged. Opcode 6 returns p+constant and writes it back. Both wrap modulo 2^16.
- R5: Circular opcodes use the length N from bsize_i, and mask = all bits up to the highest set bit of N. The base is p with the mask bits cleared, and offset = p & mask. The new offset is offset+step, minus N if the result is ≥ N, plus N if it is negative. The base bits are kept. The steps are: 7 (+1), 8 (−1), 9 (+index), 10 (−index) and 11 (signed constant). Codes 7–10 return the old p. Code 11 returns the new pointer and writes it back. Example: N=30, p=101Dh with step +1 gives 1000h.
- R6: With bsize_i = 0, circular opcodes behave as the plain linear step modulo 2^16.
- R7: Opcode 12 (reverse-carry add of the index) and opcode 13 (reverse-carry subtract) return the old p. The new pointer is bitrev(bitrev(p) ± bitrev(index)). With index 8, repeated opcode 12 from 0 gives 0, 8, 4, 12, 2.
- R8: The index is the value of pointer 0 before the current request, including when pointer 0 is itself the pointer being modified.
- R9: With dual_i=1, only pointers 2–5 and opcodes 0, 1, 2 and 9 are allowed. Any other combination gives err_o=1 and addr_valid_o=0 after the edge, and no pointer changes.
- R10: Opcode 15 is reserved. It is refused in the same way as an illegal request in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| dual_i | input | 1 | Request is part of a paired (dual-operand) access |
| sel_i | input | 3 | Pointer select |
| op_i | input | 4 | Update opcode |
| konst_i | input | 16 | Long constant (offset or load value) |
| bsize_i | input | 16 | Circular buffer length N |
| addr_o | output | 16 | Access address of the last accepted request |
| addr_valid_o | output | 1 | addr_o belongs to a request accepted on the last edge |
| err_o | output | 1 | The request on the last edge was refused |

## Verification
A corrupted pointer or a misapplied step is not flagged at once. It shows up as a wrong addr_o on the next request that uses that pointer, so the bench reads pointers back with opcode 0 right after each directed update. A wrong index breaks every later index and bit-reversed step, so pointer 0 is reloaded and re-read between phases. A refused request that still writes shows only when the refused pointer is next read, so a read follows each illegal request.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  typedef enum logic [3:0] {
    OP_NONE   = 4'd0,
    OP_INC    = 4'd1,
    OP_DEC    = 4'd2,
    OP_INCX   = 4'd3,
    OP_DECX   = 4'd4,
    OP_OFS    = 4'd5,
    OP_PREADD = 4'd6,
    OP_CINC   = 4'd7,
    OP_CDEC   = 4'd8,
    OP_CINCX  = 4'd9,
    OP_CDECX  = 4'd10,
    OP_CPRE   = 4'd11,
    OP_BRINC  = 4'd12,
    OP_BRDEC  = 4'd13,
    OP_LOAD   = 4'd14,
    OP_RSVD   = 4'd15
  } ptr_op_e;
endpackage

// File: rtl/ptr_bank.sv
module ptr_bank #(
  parameter int W    = 16,
  parameter int NPTR = 8,
  localparam int SW  = $clog2(NPTR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [W-1:0]  wdata,
  input  logic [SW-1:0] rsel,
  output logic [W-1:0]  rdata,
  output logic [W-1:0]  idx
);
  logic [W-1:0] regs [NPTR];

  for (genvar g = 0; g < NPTR; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           regs[g] <= '0;
      else if (we && wsel == SW'(g))        regs[g] <= wdata;
    end
  end

  assign rdata = regs[rsel];
  assign idx   = regs[0];
endmodule

// File: rtl/ptr_legal.sv
module ptr_legal #(
  parameter int NPTR = 8,
  parameter int DLO  = 2,
  parameter int DHI  = 5,
  localparam int SW  = $clog2(NPTR)
) (
  input  logic          dual,
  input  logic [SW-1:0] sel,
  input  logic [3:0]    op,
  output logic          illegal
);
  import ptr_pkg::*;
  logic sel_ok, op_ok;

  always_comb begin
    sel_ok = (int'(sel) >= DLO) && (int'(sel) <= DHI);
    unique case (ptr_op_e'(op))
      OP_NONE, OP_INC, OP_DEC, OP_CINCX: op_ok = 1'b1;
      default:                           op_ok = 1'b0;
    endcase
    illegal = (ptr_op_e'(op) == OP_RSVD) || (dual && !(sel_ok && op_ok));
  end
endmodule

// File: rtl/ptr_alu.sv
module ptr_alu #(
  parameter int W = 16
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] idx,
  input  logic [W-1:0] konst,
  input  logic [W-1:0] bsize,
  output logic [W-1:0] addr,
  output logic [W-1:0] nxt,
  output logic         wr,
  output logic         circ,
  output logic [W-1:0] mask
);
  import ptr_pkg::*;

  function automatic logic [W-1:0] bitrev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  function automatic logic [W-1:0] len_mask(input logic [W-1:0] n);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = |(n >> i);
    return m;
  endfunction

  function automatic logic [W-1:0] circ_step(input logic [W-1:0] p,
                                             input logic signed [W:0] step,
                                             input logic [W-1:0] n);
    logic [W-1:0] m, base;
    logic signed [W+1:0] s, nn;
    if (n == '0) return p + step[W-1:0];
    m    = len_mask(n);
    base = p & ~m;
    nn   = $signed({2'b00, n});
    s    = $signed({2'b00, p & m}) + $signed({step[W], step});
    if (s < 0)        s = s + nn;
    else if (s >= nn) s = s - nn;
    return base | (s[W-1:0] & m);
  endfunction

  logic signed [W:0] st_pos_x, st_neg_x, st_k;
  logic [W-1:0] padd;

  always_comb begin
    st_pos_x = $signed({1'b0, idx});
    st_neg_x = -$signed({1'b0, idx});
    st_k     = $signed({konst[W-1], konst});
    padd     = cur + konst;
    mask     = len_mask(bsize);
    addr     = cur;
    nxt      = cur;
    wr       = 1'b1;
    circ     = 1'b0;
    unique case (ptr_op_e'(op))
      OP_NONE:   wr = 1'b0;
      OP_INC:    nxt = cur + W'(1);
      OP_DEC:    nxt = cur - W'(1);
      OP_INCX:   nxt = cur + idx;
      OP_DECX:   nxt = cur - idx;
      OP_OFS:    begin addr = padd; wr = 1'b0; end
      OP_PREADD: begin addr = padd; nxt = padd; end
      OP_CINC:   begin circ = 1'b1; nxt = circ_step(cur, (W+1)'(1), bsize); end
      OP_CDEC:   begin circ = 1'b1; nxt = circ_step(cur, -(W+1)'(1), bsize); end
      OP_CINCX:  begin circ = 1'b1; nxt = circ_step(cur, st_pos_x, bsize); end
      OP_CDECX:  begin circ = 1'b1; nxt = circ_step(cur, st_neg_x, bsize); end
      OP_CPRE:   begin circ = 1'b1; nxt = circ_step(cur, st_k, bsize); addr = nxt; end
      OP_BRINC:  nxt = bitrev(bitrev(cur) + bitrev(idx));
      OP_BRDEC:  nxt = bitrev(bitrev(cur) - bitrev(idx));
      OP_LOAD:   begin addr = konst; nxt = konst; end
      default:   wr = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptr_unit.sv
module ptr_unit #(
  parameter int W    = 16,
  parameter int NPTR = 8,
  localparam int SW  = $clog2(NPTR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid_i,
  input  logic          dual_i,
  input  logic [SW-1:0] sel_i,
  input  logic [3:0]    op_i,
  input  logic [W-1:0]  konst_i,
  input  logic [W-1:0]  bsize_i,
  output logic [W-1:0]  addr_o,
  output logic          addr_valid_o,
  output logic          err_o
);
  logic [W-1:0] cur_ptr, idx_val, alu_addr, alu_nxt, circ_mask;
  logic         alu_wr, circ_ev, illegal, accept, wr_en;

  ptr_bank #(.W(W), .NPTR(NPTR)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .wsel(sel_i), .wdata(alu_nxt),
    .rsel(sel_i), .rdata(cur_ptr), .idx(idx_val)
  );

  ptr_legal #(.NPTR(NPTR)) u_legal (
    .dual(dual_i), .sel(sel_i), .op(op_i), .illegal(illegal)
  );

  ptr_alu #(.W(W)) u_alu (
    .op(op_i), .cur(cur_ptr), .idx(idx_val), .konst(konst_i), .bsize(bsize_i),
    .addr(alu_addr), .nxt(alu_nxt), .wr(alu_wr), .circ(circ_ev), .mask(circ_mask)
  );

  assign accept = req_valid_i && !illegal;
  assign wr_en  = accept && alu_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o       <= '0;
      addr_valid_o <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      addr_valid_o <= accept;
      err_o        <= req_valid_i && illegal;
      if (accept) addr_o <= alu_addr;
    end
  end
endmodule

// File: rtl/ptr_unit_chk.sv
module ptr_unit_chk #(
  parameter int W  = 16,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid_i,
  input logic          dual_i,
  input logic [SW-1:0] sel_i,
  input logic [3:0]    op_i,
  input logic [W-1:0]  bsize_i,
  input logic [W-1:0]  addr_o,
  input logic          addr_valid_o,
  input logic          err_o,
  input logic          illegal,
  input logic          wr_en,
  input logic          circ_ev,
  input logic [W-1:0]  circ_mask,
  input logic [W-1:0]  cur_ptr,
  input logic [W-1:0]  alu_nxt
);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> (!addr_valid_o && !err_o));
  p_accept_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !illegal) |=> (addr_valid_o && !err_o));
  p_none_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd0 || op_i == 4'd5) |-> !wr_en);
  p_circ_in_buf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && circ_ev && bsize_i != '0 && ((cur_ptr & circ_mask) < bsize_i))
      |-> (((alu_nxt & circ_mask) < bsize_i) &&
           ((alu_nxt & ~circ_mask) == (cur_ptr & ~circ_mask))));
  p_dual_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dual_i) |-> (sel_i >= SW'(2) && sel_i <= SW'(5)));
  p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && illegal) |=> (err_o && !addr_valid_o && $stable(addr_o)));
  p_rsvd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd15) |-> (illegal && !wr_en));
endmodule

bind ptr_unit ptr_unit_chk #(.W(W), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .dual_i(dual_i),
  .sel_i(sel_i), .op_i(op_i), .bsize_i(bsize_i), .addr_o(addr_o),
  .addr_valid_o(addr_valid_o), .err_o(err_o), .illegal(illegal),
  .wr_en(wr_en), .circ_ev(circ_ev), .circ_mask(circ_mask),
  .cur_ptr(cur_ptr), .alu_nxt(alu_nxt)
);

// File: tb/tb_ptr_unit.sv
module tb_ptr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0, dual_i = 1'b0;
  logic [2:0]  sel_i = '0;
  logic [3:0]  op_i = '0;
  logic [15:0] konst_i = '0, bsize_i = '0;
  logic [15:0] addr_o;
  logic        addr_valid_o, err_o;

  int n_tests = 0, n_fail = 0;
  logic [15:0] m_ptr [8];

  ptr_unit dut (.*);

  always #2 clk = ~clk;

  function automatic logic [15:0] rv(input logic [15:0] v);
    logic [15:0] r = '0;
    for (int i = 0; i < 16; i++) if (v[i]) r[15-i] = 1'b1;
    return r;
  endfunction

  function automatic logic [15:0] m_circ(input logic [15:0] p, input int step, input logic [15:0] n);
    int b, lim, o;
    if (n == 0) return p + 16'(step);
    lim = 1;
    while (lim <= int'(n)) lim = lim * 2;
    b = int'(p) - (int'(p) % lim);
    o = (int'(p) % lim) + step;
    o = ((o % int'(n)) + int'(n)) % int'(n);
    return 16'(b + o);
  endfunction

  function automatic bit m_illegal(input bit d, input int s, input int o);
    if (o == 15) return 1;
    if (!d) return 0;
    if (s < 2 || s > 5) return 1;
    return !(o == 0 || o == 1 || o == 2 || o == 9);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // issue one request at a negedge, check outputs at the following negedge
  task automatic req(input string tag, input bit d, input int s, input int o,
                     input logic [15:0] k, input logic [15:0] n);
    logic [15:0] p, ix, ea, np;
    bit ill, w;
    p = m_ptr[s]; ix = m_ptr[0]; ea = p; np = p; w = 1;
    ill = m_illegal(d, s, o);
    case (o)
      0: w = 0;
      1: np = p + 1;
      2: np = p - 1;
      3: np = p + ix;
      4: np = p - ix;
      5: begin ea = p + k; w = 0; end
      6: begin ea = p + k; np = ea; end
      7: np = m_circ(p, 1, n);
      8: np = m_circ(p, -1, n);
      9: np = m_circ(p, int'(ix), n);
      10: np = m_circ(p, -int'(ix), n);
      11: begin np = m_circ(p, int'($signed(k)), n); ea = np; end
      12: np = rv(rv(p) + rv(ix));
      13: np = rv(rv(p) - rv(ix));
      14: begin ea = k; np = k; end
      default: w = 0;
    endcase
    req_valid_i = 1'b1; dual_i = d; sel_i = 3'(s); op_i = 4'(o);
    konst_i = k; bsize_i = n;
    @(negedge clk);
    req_valid_i = 1'b0;
    if (ill) begin
      check({tag, " err"}, {31'd0, err_o}, 32'd1);
      check({tag, " valid"}, {31'd0, addr_valid_o}, 32'd0);
    end else begin
      check({tag, " valid"}, {31'd0, addr_valid_o}, 32'd1);
      check({tag, " addr"}, {16'd0, addr_o}, {16'd0, ea});
      if (w) m_ptr[s] = np;
    end
  endtask

  task automatic rd(input string tag, input int s);
    req({tag, " readback"}, 0, s, 0, 16'h0, 16'h0);
  endtask

  initial begin
    int seed = 0;
    for (int i = 0; i < 8; i++) m_ptr[i] = '0;
    #1;
    check("R1 addr", {16'd0, addr_o}, 32'd0);
    check("R1 valid", {31'd0, addr_valid_o}, 32'd0);
    check("R1 err", {31'd0, err_o}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) rd("R1", i);
    @(negedge clk);
    check("R2 idle valid", {31'd0, addr_valid_o}, 32'd0);
    check("R2 idle err", {31'd0, err_o}, 32'd0);

    // R3 linear and wrap
    req("R3 load", 0, 1, 14, 16'hFFFF, 0);
    req("R3 inc wrap", 0, 1, 1, 0, 0); rd("R3", 1);
    req("R3 dec wrap", 0, 1, 2, 0, 0); rd("R3", 1);
    req("R3 idx load", 0, 0, 14, 16'h0010, 0);
    req("R3 incx", 0, 1, 3, 0, 0); rd("R3", 1);
    req("R3 decx", 0, 1, 4, 0, 0); rd("R3", 1);
    // R4 constant offset
    req("R4 ofs", 0, 3, 14, 16'h1234, 0);
    req("R4 ofs nowb", 0, 3, 5, 16'h0100, 0); rd("R4", 3);
    req("R4 preadd", 0, 3, 6, 16'hF000, 0); rd("R4", 3);
    // R5 circular, N=30 and N=32
    req("R5 load", 0, 4, 14, 16'h101D, 0);
    req("R5 cinc n30", 0, 4, 7, 0, 16'd30); rd("R5", 4);
    check("R5 base wrap", {16'd0, m_ptr[4]}, 32'h1000);
    req("R5 cdec n30", 0, 4, 8, 0, 16'd30); rd("R5", 4);
    check("R5 end wrap", {16'd0, m_ptr[4]}, 32'h101D);
    req("R5 load32", 0, 5, 14, 16'h201F, 0);
    req("R5 cinc n32", 0, 5, 7, 0, 16'd32); rd("R5", 5);
    check("R5 n32 wrap", {16'd0, m_ptr[5]}, 32'h2000);
    req("R5 cpre", 0, 5, 11, 16'hFFFE, 16'd32); rd("R5", 5);
    req("R5 idx", 0, 0, 14, 16'd7, 0);
    req("R5 cincx", 0, 5, 9, 0, 16'd32); rd("R5", 5);
    req("R5 cdecx", 0, 5, 10, 0, 16'd32); rd("R5", 5);
    // R6 size zero
    req("R6 load", 0, 6, 14, 16'hFFFF, 0);
    req("R6 cinc n0", 0, 6, 7, 0, 0); rd("R6", 6);
    // R7 bit reversed sequence
    req("R7 idx", 0, 0, 14, 16'd8, 0);
    req("R7 load", 0, 2, 14, 16'd0, 0);
    for (int i = 0; i < 5; i++) req("R7 brinc", 0, 2, 12, 0, 0);
    rd("R7", 2);
    req("R7 brdec", 0, 2, 13, 0, 0); rd("R7", 2);
    // R8 index self-modify
    req("R8 selfx", 0, 0, 3, 0, 0); rd("R8", 0);
    check("R8 doubled", {16'd0, m_ptr[0]}, 32'd16);
    // R9 dual restrictions
    req("R9 bad sel", 1, 1, 1, 0, 0); rd("R9", 1);
    req("R9 bad op", 1, 3, 6, 16'h0005, 0); rd("R9", 3);
    req("R9 bad sel6", 1, 6, 0, 0, 0);
    req("R9 ok cincx", 1, 2, 9, 0, 16'd64); rd("R9", 2);
    req("R9 ok dec", 1, 5, 2, 0, 0); rd("R9", 5);
    // R10 reserved
    req("R10 rsvd", 0, 4, 15, 16'h1111, 0); rd("R10", 4);

    // random mix
    seed = $urandom(32'h5EED);
    for (int t = 0; t < 400; t++) begin
      int s, o, n, ps;
      bit d;
      logic [15:0] k;
      s = int'($urandom_range(0, 7));
      o = int'($urandom_range(0, 15));
      d = ($urandom_range(0, 5) == 0);
      n = int'($urandom_range(1, 100));
      k = 16'($urandom);
      if (o >= 7 && o <= 11) begin
        int lim = 1, st;
        while (lim <= n) lim = lim * 2;
        ps = int'(m_ptr[s]) % lim;
        st = (o == 11) ? int'($signed(k)) : ((o == 9 || o == 10) ? int'(m_ptr[0]) : 1);
        if (st < 0) st = -st;
        if (ps >= n || st > n) begin
          if (o == 11) k = 16'(int'($urandom_range(0, 2 * n)) - n);
          else o = 0;
          if (ps >= n) o = 0;
        end
      end
      req("RAND R3 R4 R5 R7 R8 R9 R10", d, s, o, k, 16'(n));
    end
    for (int i = 0; i < 8; i++) rd("RAND final", i);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule